// File: doc/BRIEF.md
# Programmable-Priority Vectored Interrupt Controller

This block collects thirteen peripheral request lines and drives one interrupt line to a processor core. Each source has its own pending flag, its own enable bit and a 4-bit priority set by software. When the line is raised, the block also gives a vector index that names the one source being served. The core takes the vector, runs the handler and pulses an acknowledge. The acknowledge clears the flag of the vector that was served. The block then picks the next source.

A three-state machine runs the output. The states are IDLE, ASSERT and GAP. IDLE goes to ASSERT ("grant") when some enabled source is pending, and the winning index is latched into the vector register. ASSERT goes to GAP ("retire") on an acknowledge. ASSERT goes back to IDLE ("withdraw") when the presented source is no longer both enabled and pending. GAP always goes to IDLE ("settle") after one cycle, so the core always sees the line fall between two vectors. The pending flags can be read, and cleared by writing ones, through a small register port. Enables and priorities are written and read through the same port.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, irq_o is 0 and vec_o is 0. The enable register, the pending register and all priority registers read 0.
- R2: When a request input goes from 0 to 1, the pending flag of that source is set on that clock edge. A request held high does not set the flag again after the flag has been cleared.
- R3: A pending flag is cleared only in two ways: an acknowledge of that source's vector, or a register write to address 1 with a 1 in the source's bit. Bits written as 0 have no effect.
- R4: A source whose enable bit is 0 still sets its pending flag, and the flag can be read at address 1. Such a source never raises irq_o.
- R5: Among the sources that are enabled and pending, the one with the numerically largest priority value is chosen. When two sources have the same value, the lower source index wins.
- R6: irq_o and vec_o come from registers. irq_o rises on the second clock edge after the request input rises: the first edge sets the flag, the second edge grants.
- R7: While irq_o stays high, vec_o does not change. A new source with a higher priority, or a change to a priority register, does not replace the presented vector.
- R8: An acknowledge sampled while irq_o is high clears the flag of vec_o. irq_o then stays low for exactly two cycles (GAP, then IDLE) before the next grant. An acknowledge sampled while irq_o is low has no effect.
- R9: If the presented source stops being both enabled and pending without an acknowledge, irq_o falls on the next clock edge.
- R10: If a rising request edge falls on the same clock edge as a clear of that source (by acknowledge or by a write to address 1), the flag ends up set.
- R11: The register map is as follows. Address 0 holds the enable bits 12:0. Address 1 holds the pending bits 12:0 (write 1 to clear). Addresses 2 to 14 hold the priority of sources 0 to 12 in bits 3:0. Unused bits and all other addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 13 | Request lines. A rising edge is one event. |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data (combinational) |
| irq_o | output | 1 | Interrupt line to the core |
| vec_o | output | 4 | Index of the presented source |
| ack_i | input | 1 | Acknowledge from the core |

## Verification
Two functions can act on the same flag in one cycle. A rising request edge can set a flag while the core's acknowledge or a software clear removes it. The bench makes both cases happen. It raises a source's request on the exact edge that acknowledges that source. It also raises a disabled source's request on the same edge as a clear write to that source's pending bit. In both cases it reads the pending register afterwards and expects the bit to be set. After the acknowledge case, it expects the same vector to be granted again once the GAP and IDLE cycles have passed.

// File: rtl/pic_pkg.sv
package pic_pkg;
    parameter int NSRC   = 13;
    parameter int PRIO_W = 4;
    parameter int IDX_W  = $clog2(NSRC);
    parameter int ADDR_W = 5;
    parameter int DATA_W = 16;

    localparam int A_ENABLE  = 0;
    localparam int A_PENDING = 1;
    localparam int A_PRIO0   = 2;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_ASSERT = 2'd1,
        S_GAP    = 2'd2
    } pic_state_e;
endpackage

// File: rtl/pic_edge_flags.sv
module pic_edge_flags
    import pic_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] req_i,
    input  logic [NSRC-1:0] clr_i,
    output logic [NSRC-1:0] pend_o
);
    logic [NSRC-1:0] req_q;
    logic [NSRC-1:0] rise;

    assign rise = req_i & ~req_q;

    genvar g;
    generate
        for (g = 0; g < NSRC; g++) begin : g_flag
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    req_q[g]  <= 1'b0;
                    pend_o[g] <= 1'b0;
                end else begin
                    req_q[g] <= req_i[g];
                    // a new event beats a clear on the same edge
                    if (rise[g])
                        pend_o[g] <= 1'b1;
                    else if (clr_i[g])
                        pend_o[g] <= 1'b0;
                end
            end

            // R2 / R10: an edge always leaves the flag set
            p_rise_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
                rise[g] |=> pend_o[g]);
            // R3: flag falls only with a clear request
            p_clear_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(pend_o[g]) |-> $past(clr_i[g]));
        end
    endgenerate
endmodule

// File: rtl/pic_prio_pick.sv
module pic_prio_pick
    import pic_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NSRC-1:0]              cand_i,
    input  logic [NSRC-1:0][PRIO_W-1:0]  prio_i,
    output logic                         valid_o,
    output logic [IDX_W-1:0]             idx_o
);
    logic [PRIO_W-1:0] best;

    always_comb begin
        valid_o = 1'b0;
        idx_o   = '0;
        best    = '0;
        for (int i = 0; i < NSRC; i++) begin
            // strict compare keeps the lower index on a tie
            if (cand_i[i] && (!valid_o || prio_i[i] > best)) begin
                valid_o = 1'b1;
                idx_o   = IDX_W'(i);
                best    = prio_i[i];
            end
        end
    end

    // R5: the winner is a live candidate, and nothing live goes unseen
    p_win_live_r5: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> cand_i[idx_o]);
    p_none_live_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> (cand_i == '0));
endmodule

// File: rtl/pic_regs.sv
module pic_regs
    import pic_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_i,
    input  logic [ADDR_W-1:0]            addr_i,
    input  logic [DATA_W-1:0]            wdata_i,
    input  logic [NSRC-1:0]              pend_i,
    output logic [DATA_W-1:0]            rdata_o,
    output logic [NSRC-1:0]              en_o,
    output logic [NSRC-1:0][PRIO_W-1:0]  prio_o,
    output logic [NSRC-1:0]              w1c_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            en_o <= '0;
        else if (wr_i && addr_i == ADDR_W'(A_ENABLE))
            en_o <= wdata_i[NSRC-1:0];
    end

    assign w1c_o = (wr_i && addr_i == ADDR_W'(A_PENDING)) ? wdata_i[NSRC-1:0] : '0;

    genvar g;
    generate
        for (g = 0; g < NSRC; g++) begin : g_prio
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    prio_o[g] <= '0;
                else if (wr_i && addr_i == ADDR_W'(A_PRIO0 + g))
                    prio_o[g] <= wdata_i[PRIO_W-1:0];
            end
        end
    endgenerate

    always_comb begin
        rdata_o = '0;
        if (addr_i == ADDR_W'(A_ENABLE))
            rdata_o[NSRC-1:0] = en_o;
        else if (addr_i == ADDR_W'(A_PENDING))
            rdata_o[NSRC-1:0] = pend_i;
        else begin
            for (int i = 0; i < NSRC; i++)
                if (addr_i == ADDR_W'(A_PRIO0 + i))
                    rdata_o[PRIO_W-1:0] = prio_o[i];
        end
    end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import pic_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [12:0]       req_i,
    input  logic              reg_wr_i,
    input  logic [4:0]        reg_addr_i,
    input  logic [15:0]       reg_wdata_i,
    output logic [15:0]       reg_rdata_o,
    output logic              irq_o,
    output logic [3:0]        vec_o,
    input  logic              ack_i
);
    pic_state_e state_q, state_nx;

    logic [NSRC-1:0]             pend, en, w1c, ack_clr, live, live_prev;
    logic [NSRC-1:0][PRIO_W-1:0] prio;
    logic                        win_valid;
    logic [IDX_W-1:0]            win_idx;
    logic                        irq_q;
    logic [IDX_W-1:0]            vec_q;
    logic                        taken;

    assign live = pend & en;

    pic_regs u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_i(reg_wr_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
        .pend_i(pend), .rdata_o(reg_rdata_o),
        .en_o(en), .prio_o(prio), .w1c_o(w1c)
    );

    pic_edge_flags u_flags (
        .clk(clk), .rst_n(rst_n),
        .req_i(req_i), .clr_i(w1c | ack_clr), .pend_o(pend)
    );

    pic_prio_pick u_pick (
        .clk(clk), .rst_n(rst_n),
        .cand_i(live), .prio_i(prio),
        .valid_o(win_valid), .idx_o(win_idx)
    );

    assign taken   = (state_q == S_ASSERT) && ack_i;
    assign ack_clr = taken ? (NSRC'(1) << vec_q) : '0;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_nx;
    end

    // transitions: grant, retire, withdraw, settle
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            S_IDLE:   if (win_valid)        state_nx = S_ASSERT;
            S_ASSERT: if (ack_i)            state_nx = S_GAP;
                      else if (!live[vec_q]) state_nx = S_IDLE;
            S_GAP:                          state_nx = S_IDLE;
            default:                        state_nx = S_IDLE;
        endcase
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
            vec_q <= '0;
        end else begin
            irq_q <= (state_nx == S_ASSERT);
            if (state_q == S_IDLE && win_valid)
                vec_q <= win_idx;
        end
    end

    assign irq_o = irq_q;
    assign vec_o = vec_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) live_prev <= '0;
        else        live_prev <= live;
    end

    // R4: a grant only goes to a source that was enabled and pending
    p_grant_live_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> live_prev[vec_o]);
    // R7: no change of vector while the line stays high
    p_vec_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && $past(irq_o)) |-> $stable(vec_o));
    // R8: acknowledge drops the line, and it stays low one more cycle
    p_ack_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && ack_i) |=> !irq_o);
    p_gap_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(irq_o && ack_i) |=> !irq_o);
    // R9: a dead presented source withdraws the line
    p_withdraw_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !ack_i && !live[vec_o]) |=> !irq_o);
endmodule

// File: tb/prio_irq_ctrl_tb_top.sv
module prio_irq_ctrl_tb_top;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [12:0] req_i = '0;
    logic        reg_wr_i = 0;
    logic [4:0]  reg_addr_i = '0;
    logic [15:0] reg_wdata_i = '0;
    logic [15:0] reg_rdata_o;
    logic        irq_o;
    logic [3:0]  vec_o;
    logic        ack_i = 0;

    int checks = 0;
    int errors = 0;
    int exp_q[$];
    logic irq_seen = 0;

    always #2 clk = ~clk;

    prio_irq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .req_i(req_i),
        .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i),
        .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
        .irq_o(irq_o), .vec_o(vec_o), .ack_i(ack_i)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        reg_wr_i = 1; reg_addr_i = 5'(a); reg_wdata_i = 16'(d);
        @(negedge clk);
        reg_wr_i = 0;
    endtask

    task automatic rd(input int a, output int d);
        reg_addr_i = 5'(a);
        #1;
        d = int'(reg_rdata_o);
    endtask

    task automatic pulse(input int idx);
        @(negedge clk);
        req_i[idx] = 1;
        @(negedge clk);
        req_i[idx] = 0;
    endtask

    task automatic ack();
        @(negedge clk);
        ack_i = 1;
        @(negedge clk);
        ack_i = 0;
    endtask

    // monitor: each new grant must match the oldest expected vector (R5)
    always @(negedge clk) begin
        if (rst_n && irq_o && !irq_seen) begin
            if (exp_q.size() == 0)
                chk("R5 unexpected grant", int'(vec_o), -1);
            else
                chk("R5 grant order", int'(vec_o), exp_q.pop_front());
        end
        irq_seen = irq_o;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int v;
        cyc(3);
        // R1 reset state
        chk("R1 irq", int'(irq_o), 0);
        chk("R1 vec", int'(vec_o), 0);
        rd(0, v); chk("R1 enable", v, 0);
        rd(1, v); chk("R1 pending", v, 0);
        rd(6, v); chk("R1 prio", v, 0);
        rst_n = 1;

        // R11 register map
        wr(5, 'hFA);
        rd(5, v); chk("R11 prio src3", v, 'hA);
        wr(0, 'hFFFF);
        rd(0, v); chk("R11 enable mask", v, 'h1FFF);
        rd(20, v); chk("R11 unused addr", v, 0);
        wr(0, 0);

        // R4 disabled source latches but stays silent
        pulse(5);
        cyc(4);
        chk("R4 irq silent", int'(irq_o), 0);
        rd(1, v); chk("R4 pending seen", v, 1 << 5);
        // R3 write of zeros keeps it, write of one clears
        wr(1, 'h0000);
        rd(1, v); chk("R3 zero write", v, 1 << 5);
        wr(1, 1 << 5);
        rd(1, v); chk("R3 w1c", v, 0);

        // R5/R6: tie on 9 between 7 and 9, 2 lower
        wr(0, 'h1FFF);
        wr(2 + 2, 5);
        wr(2 + 7, 9);
        wr(2 + 9, 9);
        exp_q.push_back(7); exp_q.push_back(9); exp_q.push_back(2);
        @(negedge clk);
        req_i[2] = 1; req_i[7] = 1; req_i[9] = 1;
        cyc(1); chk("R6 not yet", int'(irq_o), 0);
        cyc(1); chk("R6 raised", int'(irq_o), 1);
        chk("R5 tie vec", int'(vec_o), 7);

        // R8 acknowledge: two low cycles then next grant
        ack();
        chk("R8 low1", int'(irq_o), 0);
        rd(1, v); chk("R8 cleared", v, (1 << 2) | (1 << 9));
        cyc(1); chk("R8 low2", int'(irq_o), 0);
        cyc(1); chk("R8 regrant", int'(irq_o), 1);
        chk("R5 next vec", int'(vec_o), 9);

        // R7 raise priority of 2 while 9 is shown
        wr(2 + 2, 15);
        cyc(2);
        chk("R7 vec held", int'(vec_o), 9);
        ack();
        cyc(2);
        chk("R7 then 2", int'(vec_o), 2);
        ack();
        cyc(4);
        // R2 held request does not re-arm
        rd(1, v); chk("R2 no rearm", v, 0);
        chk("R2 irq low", int'(irq_o), 0);
        @(negedge clk);
        req_i = '0;

        // R9 withdraw by software clear
        exp_q.push_back(4);
        pulse(4);
        cyc(2);
        chk("R9 shown", int'(irq_o), 1);
        wr(1, 1 << 4);
        chk("R9 still high", int'(irq_o), 1);
        cyc(1); chk("R9 withdrawn", int'(irq_o), 0);

        // R8 acknowledge while idle is ignored
        wr(0, 'h1FFE);
        pulse(0);
        cyc(2);
        ack();
        rd(1, v); chk("R8 idle ack", v, 1);
        wr(1, 1);

        // R10 rise on the acknowledge edge
        exp_q.push_back(6);
        pulse(6);
        cyc(2);
        chk("R10 shown", int'(vec_o), 6);
        exp_q.push_back(6);
        @(negedge clk);
        ack_i = 1; req_i[6] = 1;
        @(negedge clk);
        ack_i = 0;
        chk("R10 gap", int'(irq_o), 0);
        rd(1, v); chk("R10 ack vs rise", v, 1 << 6);
        cyc(2);
        chk("R10 regrant", int'(irq_o), 1);
        ack();
        req_i[6] = 0;

        // R10 rise on a w1c edge, disabled source
        wr(0, 0);
        @(negedge clk);
        reg_wr_i = 1; reg_addr_i = 5'd1; reg_wdata_i = 16'(1 << 11);
        req_i[11] = 1;
        @(negedge clk);
        reg_wr_i = 0; req_i[11] = 0;
        rd(1, v); chk("R10 w1c vs rise", v, 1 << 11);

        cyc(4);
        chk("R5 queue drained", exp_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule